// File: doc/BRIEF.md
# Constant-Activity DAC Bit Driver

This block drives the switch lines of a small binary DAC so that the driver stage makes the same number of transitions in every sample, whatever the code stream does. Each code bit has a differential data pair and a differential dummy pair. In each sample a bit either moves its data pair, when its value differs from the one already driven, or toggles its dummy pair, when the value repeats. Every bit therefore produces exactly two edges per sample. The current drawn from the driver supply then carries no information about the data.

A sample is taken on a clock edge only while the sampler is in its hold phase (`hold_en` high) and the half-rate phase input has flipped since the last accepted sample. This keeps the DAC code changing only during hold, and at most once per sample slot. All lines come from one register stage, so data and dummy edges line up on the same clock edge. The asynchronous active-low reset is released through a two-stage synchroniser.

Top module: `cad_driver`

## Requirements
- R1: While reset is asserted, and after it is released, until the first accepted sample, every `sw_p` bit is 0, every `sw_n` bit is 1, every `dmy_p` bit is 0 and every `dmy_n` bit is 1.
- R2: A sample is accepted on a rising clock edge only when `hold_en` is 1 and `half_phase` differs from the phase value recorded at the previous accepted sample. The recorded value is 0 after reset, and each accepted sample records the `half_phase` value it was accepted with.
- R3: On an accepted sample, for each bit i whose `code[i]` differs from the current `sw_p[i]`, `sw_p[i]` takes `code[i]` after that edge and the dummy pair of bit i holds its levels.
- R4: On an accepted sample, for each bit i whose `code[i]` equals the current `sw_p[i]` (the XNOR of the new and previous value is 1), `dmy_p[i]` and `dmy_n[i]` invert after that edge and the data pair of bit i holds its levels.
- R5: `sw_n` is always the bitwise complement of `sw_p`, and `dmy_n` is always the bitwise complement of `dmy_p`.
- R6: On an edge where no sample is accepted, because `hold_en` is 0 or `half_phase` has not flipped, no output changes and the stored previous code is kept for the next comparison.
- R7: After reset the previous code is all zeros: on the first accepted sample a code bit of 0 toggles that bit's dummy pair and a code bit of 1 switches its data pair.
- R8: Across all four line groups, each accepted sample produces exactly 2*NBITS transitions for any code sequence, constant or random, and an edge with no accepted sample produces none.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| code | input | NBITS | DAC code for the next sample |
| half_phase | input | 1 | Half-rate phase, flips once per sample slot |
| hold_en | input | 1 | High while the sampler is in hold |
| sw_p | output | NBITS | True data switch lines |
| sw_n | output | NBITS | Complemented data switch lines |
| dmy_p | output | NBITS | True dummy switch lines |
| dmy_n | output | NBITS | Complemented dummy switch lines |

## Verification
The assertions check on every cycle that the complement pairs stay complementary, that nothing moves on an edge with no accepted sample, that an accepted sample takes the code into the data lines, that dummies toggle exactly where the bit repeats, and that the transition count is 2*NBITS. The bench scenarios show what a single-cycle property cannot: that a refused sample leaves the stored previous code in place for a later comparison, that the previous code is cleared by a reset in the middle of a run, and that long random and constant code streams, as well as a phase that fails to flip, give the expected line levels.

// File: rtl/cad_pkg.sv
package cad_pkg;

  // Register image of one bit lane: data pair and dummy pair.
  typedef struct packed {
    logic sw_p;
    logic sw_n;
    logic dm_p;
    logic dm_n;
  } lane_t;

  localparam lane_t LANE_RESET = '{sw_p: 1'b0, sw_n: 1'b1, dm_p: 1'b0, dm_n: 1'b1};

endpackage

// File: rtl/cad_rst_sync.sv
module cad_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= '0;
    else          sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/cad_sample_gate.sv
module cad_sample_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_en,
  input  logic half_phase,
  output logic smp_go
);

  logic ph_q;
  logic ph_d;

  // A new sample slot is marked by the half-rate phase having flipped.
  always_comb begin
    smp_go = hold_en & (half_phase ^ ph_q);
    ph_d   = ph_q;
    if (smp_go) ph_d = half_phase;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= 1'b0;
    else        ph_q <= ph_d;
  end

endmodule

// File: rtl/cad_bit_lane.sv
module cad_bit_lane
  import cad_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  smp_go,
  input  logic  code_bit,
  output lane_t lane_o
);

  lane_t lane_q;
  lane_t lane_d;
  logic  repeat_bit;

  // The driven true line doubles as the previous-code store.
  always_comb begin
    repeat_bit = ~(code_bit ^ lane_q.sw_p);
    lane_d     = lane_q;
    if (smp_go) begin
      if (repeat_bit) begin
        lane_d.dm_p = ~lane_q.dm_p;
        lane_d.dm_n = ~lane_q.dm_n;
      end else begin
        lane_d.sw_p = code_bit;
        lane_d.sw_n = ~code_bit;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lane_q <= LANE_RESET;
    else        lane_q <= lane_d;
  end

  assign lane_o = lane_q;

endmodule

// File: rtl/cad_driver.sv
module cad_driver
  import cad_pkg::*;
#(
  parameter int NBITS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NBITS-1:0] code,
  input  logic             half_phase,
  input  logic             hold_en,
  output logic [NBITS-1:0] sw_p,
  output logic [NBITS-1:0] sw_n,
  output logic [NBITS-1:0] dmy_p,
  output logic [NBITS-1:0] dmy_n
);

  logic rst_sync_n;
  logic smp_go;

  cad_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_sync_n)
  );

  cad_sample_gate i_gate (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .hold_en    (hold_en),
    .half_phase (half_phase),
    .smp_go     (smp_go)
  );

  for (genvar gi = 0; gi < NBITS; gi++) begin : g_lane
    lane_t lane;
    cad_bit_lane i_lane (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .smp_go   (smp_go),
      .code_bit (code[gi]),
      .lane_o   (lane)
    );
    assign sw_p[gi]  = lane.sw_p;
    assign sw_n[gi]  = lane.sw_n;
    assign dmy_p[gi] = lane.dm_p;
    assign dmy_n[gi] = lane.dm_n;
  end

endmodule

// File: rtl/cad_driver_chk.sv
module cad_driver_chk #(
  parameter int NBITS = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             smp_go,
  input logic             hold_en,
  input logic [NBITS-1:0] code,
  input logic [NBITS-1:0] sw_p,
  input logic [NBITS-1:0] sw_n,
  input logic [NBITS-1:0] dmy_p,
  input logic [NBITS-1:0] dmy_n
);

  localparam int EDGES = 2 * NBITS;

  // R2: a sample is never taken outside the hold phase.
  a_r2_hold_only: assert property (@(posedge clk) disable iff (!rst_n)
    smp_go |-> hold_en);

  // R5: both pairs stay complementary.
  a_r5_pairs: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_n == ~sw_p) && (dmy_n == ~dmy_p));

  // R6: nothing moves without an accepted sample.
  a_r6_idle_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_go |=> $stable(sw_p) && $stable(sw_n) && $stable(dmy_p) && $stable(dmy_n));

  // R3: the data lines take the code.
  a_r3_data_follows: assert property (@(posedge clk) disable iff (!rst_n)
    smp_go |=> sw_p == $past(code));

  // R4: dummies toggle exactly where the bit repeats.
  a_r4_dummy_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    smp_go |=> (dmy_p ^ $past(dmy_p)) == ~($past(code) ^ $past(sw_p)));

  // R8: constant edge count per accepted sample.
  a_r8_activity: assert property (@(posedge clk) disable iff (!rst_n)
    smp_go |=> $countones({sw_p ^ $past(sw_p), sw_n ^ $past(sw_n),
                           dmy_p ^ $past(dmy_p), dmy_n ^ $past(dmy_n)}) == EDGES);

endmodule

bind cad_driver cad_driver_chk #(.NBITS(NBITS)) i_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .smp_go  (smp_go),
  .hold_en (hold_en),
  .code    (code),
  .sw_p    (sw_p),
  .sw_n    (sw_n),
  .dmy_p   (dmy_p),
  .dmy_n   (dmy_n)
);

// File: tb/test_cad_driver.sv
module test_cad_driver;

  localparam int CLK_PERIOD = 10;
  localparam int NBITS      = 2;
  localparam int NVEC       = 12;

  // Entry: {hold_en, half_phase, code[1:0], exp sw_p[1:0], exp dummy toggle mask[1:0]}
  localparam logic [7:0] VEC [NVEC] = '{
    8'b11000011, 8'b10010110, 8'b11111101, 8'b11001100,
    8'b00001100, 8'b10101010, 8'b11101011, 8'b10010100,
    8'b01100100, 8'b11010111, 8'b10111101, 8'b11000000
  };

  logic             clk = 1'b0;
  logic             rst_n;
  logic [NBITS-1:0] code;
  logic             half_phase;
  logic             hold_en;
  logic [NBITS-1:0] sw_p, sw_n, dmy_p, dmy_n;
  logic [NBITS-1:0] pp, pn, pdp, pdn;
  logic [NBITS-1:0] m_p, m_dp;
  logic             m_ph;
  int               n_checks = 0;
  int               n_errors = 0;
  bit               done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cad_driver #(.NBITS(NBITS)) i_cad_driver (
    .clk(clk), .rst_n(rst_n), .code(code), .half_phase(half_phase),
    .hold_en(hold_en), .sw_p(sw_p), .sw_n(sw_n), .dmy_p(dmy_p), .dmy_n(dmy_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic snap();
    pp = sw_p; pn = sw_n; pdp = dmy_p; pdn = dmy_n;
  endtask

  function automatic int edges();
    return $countones({sw_p ^ pp, sw_n ^ pn, dmy_p ^ pdp, dmy_n ^ pdn});
  endfunction

  // Drive at the falling edge, let one rising edge pass, return at the next falling edge.
  task automatic step(input logic h, input logic ph, input logic [NBITS-1:0] c);
    snap();
    hold_en = h; half_phase = ph; code = c;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_model(input string req, input bit acc);
    chk(sw_p == m_p, req, sw_p, m_p);
    chk(dmy_p == m_dp, req, dmy_p, m_dp);
    chk((sw_n == ~sw_p) && (dmy_n == ~dmy_p), "R5 complements", {sw_n, dmy_n}, {~sw_p, ~dmy_p});
    chk(edges() == (acc ? 2*NBITS : 0), "R8 edge count", edges(), acc ? 2*NBITS : 0);
  endtask

  // Model step from the requirements (R2, R3, R4).
  task automatic model_step(input logic h, input logic ph, input logic [NBITS-1:0] c, output bit acc);
    acc = h && (ph != m_ph);
    if (acc) begin
      m_dp = m_dp ^ ~(c ^ m_p);
      m_p  = c;
      m_ph = ph;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; hold_en = 1'b0; half_phase = 1'b0; code = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    m_p = '0; m_dp = '0; m_ph = 1'b0;
  endtask

  initial begin
    bit acc;
    do_reset();
    // R1: reset state
    chk(sw_p == '0 && dmy_p == '0, "R1 reset levels", {sw_p, dmy_p}, 0);
    chk(sw_n == '1 && dmy_n == '1, "R1 reset complements", {sw_n, dmy_n}, 15);

    // Table walk (R2, R3, R4, R6)
    for (int i = 0; i < NVEC; i++) begin
      logic [7:0] v;
      v = VEC[i];
      snap();
      step(v[7], v[6], v[5:4]);
      chk(sw_p == v[3:2], "R3 table data", sw_p, v[3:2]);
      chk((dmy_p ^ pdp) == v[1:0], "R4 table dummy toggles", dmy_p ^ pdp, v[1:0]);
      chk(sw_n == ~sw_p, "R5 table complement", sw_n, ~sw_p);
      chk(edges() == ((v[1:0] == 2'b00 && v[3:2] == pp) ? 0 : 2*NBITS),
          "R6 R8 table edges", edges(), (v[1:0] == 2'b00 && v[3:2] == pp) ? 0 : 2*NBITS);
    end
    m_p = 2'b00; m_dp = dmy_p; m_ph = 1'b1;

    // R6: refused sample keeps previous code: hold low with 11, then accept 00
    step(1'b0, 1'b0, 2'b11);
    chk(sw_p == 2'b00 && edges() == 0, "R6 hold low frozen", sw_p, 0);
    model_step(1'b1, 1'b0, 2'b00, acc);
    step(1'b1, 1'b0, 2'b00);
    check_model("R6 previous code kept", acc);
    // R2: phase not flipped, no sample
    model_step(1'b1, 1'b0, 2'b11, acc);
    step(1'b1, 1'b0, 2'b11);
    check_model("R2 phase unchanged", acc);

    // R8: random code stream with alternating phase
    for (int i = 0; i < 200; i++) begin
      logic [NBITS-1:0] c;
      c = NBITS'($urandom);
      model_step(1'b1, ~m_ph, c, acc);
      step(1'b1, m_ph, c);
      check_model("R8 random stream", acc);
    end

    // R4: constant code stream, dummies toggle every sample
    for (int i = 0; i < 20; i++) begin
      model_step(1'b1, ~m_ph, 2'b11, acc);
      step(1'b1, m_ph, 2'b11);
      check_model("R4 constant stream", acc);
    end

    // R1, R7: reset in the middle of a run clears previous code
    rst_n = 1'b0;
    #1;
    chk(sw_p == '0 && dmy_p == '0 && sw_n == '1 && dmy_n == '1, "R1 async reset",
        {sw_p, dmy_p}, 0);
    do_reset();
    model_step(1'b1, 1'b1, 2'b10, acc);
    step(1'b1, 1'b1, 2'b10);
    chk(sw_p == 2'b10, "R7 first sample data", sw_p, 2);
    chk(dmy_p == 2'b01, "R7 first sample dummy", dmy_p, 1);
    check_model("R7 first sample", acc);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

endmodule